// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This combinational block takes a ten-byte window of instruction memory read at the program counter and parses the single instruction that starts at the window's first byte. The opcode byte fixes everything else. It decides whether a register-specifier byte follows and whether an eight-byte constant follows. Those two facts give the instruction length, which is 1, 2, 9 or 10 bytes, and the address of the next sequential instruction.

The block sits in the fetch stage of a simple in-order processor core. The memory supplies the window together with an error flag. The decoder returns the class and function nibbles, the two register fields, the assembled constant, the sequential successor address and a legality flag. Later stages use these to read registers and to choose the next PC.

Window byte i is carried on `fetchWindow[8*i+7:8*i]`, so byte 0 (the opcode byte) sits in the least significant bits.

Top module: `fetch_decoder`

## Requirements
- R1: Without a memory error, `instrCode` equals bits 7:4 of byte 0 and `instrFun` equals bits 3:0 of byte 0.
- R2: For class codes 2, 3, 4, 5, 6, 0xA and 0xB a register byte is present at byte 1. `regA` takes its bits 7:4 and `regB` takes its bits 3:0.
- R3: For every other class code, and on a memory error, both `regA` and `regB` read 0xF (no register).
- R4: For class codes 3, 4, 5, 7 and 8 an eight-byte little-endian constant is present. Its least significant byte is byte 2 when a register byte is present and byte 1 otherwise. When no constant is present, `constWord` is zero.
- R5: `nextPc` equals `pc` + 1 + (1 if a register byte is present) + (8 if a constant is present), computed modulo 2^64.
- R6: A class code above 0xB clears `instrValid`. Such a code takes neither a register byte nor a constant, so its length is 1.
- R7: A function code the class does not allow clears `instrValid`. Class 6 allows 0 to 3, classes 2 and 7 allow 0 to 6, and every other class allows only 0.
- R8: When `imemError` is high, the outputs read class 1 (no-op), function 0, both register fields 0xF, a zero constant, `nextPc` = `pc` + 1 and `instrValid` = 1, whatever the window holds.
- R9: The byte sequence 40 42 cd ab 89 67 45 23 01 00 (byte 0 first) decodes to class 4, function 0, `regA` 4, `regB` 2, constant 0x000123456789abcd and a length of 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | 64 | Address of the instruction's first byte |
| fetchWindow | input | 80 | Ten bytes read at `pc`, byte 0 in the low bits |
| imemError | input | 1 | Instruction memory reported a faulting read |
| instrCode | output | 4 | Instruction class nibble |
| instrFun | output | 4 | Function nibble |
| regA | output | 4 | First register field, 0xF when absent |
| regB | output | 4 | Second register field, 0xF when absent |
| constWord | output | 64 | Assembled constant, zero when absent |
| nextPc | output | 64 | Address of the following sequential instruction |
| instrValid | output | 1 | Class and function form a legal instruction |

## Verification
The bench targets where the constant starts. A decoder that takes it from a fixed offset would return a constant shifted by one byte for jumps and calls, or for register-carrying forms. It also checks byte order: a decoder that reverses the byte order yields a mirrored value on the example encoding. The full sweep over all 256 opcode bytes covers two more faults. A decoder that mislabels one class's register or constant need shows up as a wrong length for that class. A decoder with an off-by-one limit on function codes accepts function 4 for arithmetic or 7 for jumps, or rejects the highest legal value. Separate cases cover wraparound of the successor address near the top of the address space, and a memory fault on a window that would otherwise decode as a two-byte arithmetic instruction. A decoder that ignored the fault would report that arithmetic instruction and a length of 2.

// File: rtl/fetch_decode_pkg.sv
package fetch_decode_pkg;
  localparam int unsigned WINDOW_BYTES = 10;
  localparam int unsigned WORD_BYTES   = 8;
  localparam int unsigned ADDR_WIDTH   = 64;
  localparam int unsigned NIBBLE       = 4;

  localparam logic [3:0] OP_HALT  = 4'h0;
  localparam logic [3:0] OP_NOP   = 4'h1;
  localparam logic [3:0] OP_MOVE  = 4'h2;
  localparam logic [3:0] OP_IMOV  = 4'h3;
  localparam logic [3:0] OP_STORE = 4'h4;
  localparam logic [3:0] OP_LOAD  = 4'h5;
  localparam logic [3:0] OP_ALU   = 4'h6;
  localparam logic [3:0] OP_JUMP  = 4'h7;
  localparam logic [3:0] OP_CALL  = 4'h8;
  localparam logic [3:0] OP_RET   = 4'h9;
  localparam logic [3:0] OP_PUSH  = 4'hA;
  localparam logic [3:0] OP_POP   = 4'hB;

  localparam logic [3:0] ALU_FUN_MAX  = 4'd3;
  localparam logic [3:0] COND_FUN_MAX = 4'd6;
  localparam logic [3:0] NO_REG       = 4'hF;

  // strobes from control to datapath
  typedef struct packed {
    logic needRegs;
    logic needConst;
  } decodeStrobes_t;
endpackage

// File: rtl/fetch_decode_ctrl.sv
module fetch_decode_ctrl
  import fetch_decode_pkg::*;
(
  input  logic [7:0]     opByte,
  input  logic           fault,
  output logic [3:0]     instrCode,
  output logic [3:0]     instrFun,
  output logic           instrValid,
  output decodeStrobes_t strobes
);
  logic [3:0] effCode;
  logic [3:0] effFun;
  logic       funOk;
  logic       codeKnown;

  always_comb begin
    effCode = fault ? OP_NOP : opByte[7:4];
    effFun  = fault ? 4'h0   : opByte[3:0];

    strobes.needRegs  = 1'b0;
    strobes.needConst = 1'b0;
    unique case (effCode)
      OP_MOVE, OP_ALU, OP_PUSH, OP_POP: strobes.needRegs = 1'b1;
      OP_IMOV, OP_STORE, OP_LOAD: begin
        strobes.needRegs  = 1'b1;
        strobes.needConst = 1'b1;
      end
      OP_JUMP, OP_CALL: strobes.needConst = 1'b1;
      default: ;
    endcase

    codeKnown = (effCode <= OP_POP);
    unique case (effCode)
      OP_ALU:           funOk = (effFun <= ALU_FUN_MAX);
      OP_MOVE, OP_JUMP: funOk = (effFun <= COND_FUN_MAX);
      default:          funOk = (effFun == 4'h0);
    endcase

    instrCode  = effCode;
    instrFun   = effFun;
    instrValid = codeKnown && funOk;
  end

  always_comb begin
    if (!$isunknown({opByte, fault})) begin
      // R8
      if (fault) fault_nop_chk: assert (instrCode == OP_NOP && instrValid && !strobes.needRegs);
      // R6
      if (!fault && opByte[7:4] > OP_POP) bad_code_chk: assert (!instrValid && !strobes.needConst);
      // R7
      if (instrValid && instrCode == OP_ALU) alu_fun_chk: assert (instrFun <= ALU_FUN_MAX);
    end
  end
endmodule

// File: rtl/fetch_decode_dpath.sv
module fetch_decode_dpath
  import fetch_decode_pkg::*;
#(
  parameter int unsigned TAIL_BYTES = WINDOW_BYTES - 1
) (
  input  logic [ADDR_WIDTH-1:0]   pc,
  input  logic [8*TAIL_BYTES-1:0] tailBytes,
  input  decodeStrobes_t          strobes,
  output logic [3:0]              regA,
  output logic [3:0]              regB,
  output logic [8*WORD_BYTES-1:0] constWord,
  output logic [ADDR_WIDTH-1:0]   nextPc
);
  localparam int unsigned CONST_BITS = 8 * WORD_BYTES;

  logic [CONST_BITS-1:0] constAfterReg;
  logic [CONST_BITS-1:0] constNoReg;
  logic [3:0]            stepBytes;

  // constant starts right after the opcode byte or after the register byte
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_constByte
    assign constNoReg[8*k +: 8]    = tailBytes[8*k +: 8];
    assign constAfterReg[8*k +: 8] = tailBytes[8*(k+1) +: 8];
  end

  always_comb begin
    regA = strobes.needRegs ? tailBytes[7:4] : NO_REG;
    regB = strobes.needRegs ? tailBytes[3:0] : NO_REG;
    if (!strobes.needConst)    constWord = '0;
    else if (strobes.needRegs) constWord = constAfterReg;
    else                       constWord = constNoReg;
    stepBytes = 4'd1 + {3'd0, strobes.needRegs} + (strobes.needConst ? 4'(WORD_BYTES) : 4'd0);
    nextPc    = pc + ADDR_WIDTH'(stepBytes);
  end

  always_comb begin
    if (!$isunknown({pc, strobes, nextPc})) begin
      // R5
      len_range_chk: assert ((nextPc - pc) == 64'd1 || (nextPc - pc) == 64'd2 ||
                             (nextPc - pc) == 64'd9 || (nextPc - pc) == 64'd10);
      // R3
      if (!strobes.needRegs) no_regs_chk: assert (regA == NO_REG && regB == NO_REG);
      // R4
      if (!strobes.needConst) no_const_chk: assert (constWord == '0);
    end
  end
endmodule

// File: rtl/fetch_decoder.sv
module fetch_decoder
  import fetch_decode_pkg::*;
(
  input  logic [63:0] pc,
  input  logic [79:0] fetchWindow,
  input  logic        imemError,
  output logic [3:0]  instrCode,
  output logic [3:0]  instrFun,
  output logic [3:0]  regA,
  output logic [3:0]  regB,
  output logic [63:0] constWord,
  output logic [63:0] nextPc,
  output logic        instrValid
);
  decodeStrobes_t strobes;

  fetch_decode_ctrl u_ctrl (
    .opByte    (fetchWindow[7:0]),
    .fault     (imemError),
    .instrCode (instrCode),
    .instrFun  (instrFun),
    .instrValid(instrValid),
    .strobes   (strobes)
  );

  fetch_decode_dpath u_dpath (
    .pc       (pc),
    .tailBytes(fetchWindow[79:8]),
    .strobes  (strobes),
    .regA     (regA),
    .regB     (regB),
    .constWord(constWord),
    .nextPc   (nextPc)
  );
endmodule

// File: tb/fetch_decoder_test.sv
module fetch_decoder_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [63:0] pc;
  logic [79:0] fetchWindow;
  logic        imemError;
  logic [3:0]  instrCode, instrFun, regA, regB;
  logic [63:0] constWord, nextPc;
  logic        instrValid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fetch_decoder uut (
    .pc(pc), .fetchWindow(fetchWindow), .imemError(imemError),
    .instrCode(instrCode), .instrFun(instrFun), .regA(regA), .regB(regB),
    .constWord(constWord), .nextPc(nextPc), .instrValid(instrValid)
  );

  // bytes written in reading order (byte 0 leftmost) -> window with byte 0 low
  function automatic logic [79:0] seq(input logic [79:0] inOrder);
    logic [79:0] w;
    for (int i = 0; i < 10; i++) w[8*i +: 8] = inOrder[8*(9-i) +: 8];
    return w;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] p, input logic [79:0] w, input logic e);
    @(negedge clk);
    pc = p; fetchWindow = w; imemError = e;
    #2;
  endtask

  task automatic expectAll(input string req, input logic [3:0] c, input logic [3:0] f,
                           input logic [3:0] a, input logic [3:0] b, input logic [63:0] k,
                           input logic [63:0] np, input logic v);
    chk(req, "code", 64'(instrCode), 64'(c));
    chk(req, "fun", 64'(instrFun), 64'(f));
    chk(req, "regA", 64'(regA), 64'(a));
    chk(req, "regB", 64'(regB), 64'(b));
    chk(req, "const", constWord, k);
    chk(req, "nextPc", nextPc, np);
    chk(req, "valid", 64'(instrValid), 64'(v));
  endtask

  task automatic testIdle();  // all-zero window: halt, R1 R3
    apply(64'h0, 80'h0, 1'b0);
    expectAll("R1", 4'h0, 4'h0, 4'hF, 4'hF, 64'h0, 64'h1, 1'b1);
  endtask

  task automatic testExample();  // R9 R2 R4
    apply(64'h100, seq(80'h40_42_cd_ab_89_67_45_23_01_00), 1'b0);
    expectAll("R9", 4'h4, 4'h0, 4'h4, 4'h2, 64'h0001_2345_6789_abcd, 64'h10A, 1'b1);
  endtask

  task automatic testImmMove();  // R2 R4
    apply(64'h200, seq(80'h30_f3_0f_00_00_00_00_00_00_00), 1'b0);
    expectAll("R4", 4'h3, 4'h0, 4'hF, 4'h3, 64'hF, 64'h20A, 1'b1);
  endtask

  task automatic testJumpCall();  // R4 R3: constant from byte 1
    apply(64'h300, seq(80'h73_08_07_06_05_04_03_02_01_ff), 1'b0);
    expectAll("R4", 4'h7, 4'h3, 4'hF, 4'hF, 64'h0102_0304_0506_0708, 64'h309, 1'b1);
    apply(64'h400, seq(80'h80_34_12_00_00_00_00_00_00_aa), 1'b0);
    expectAll("R4", 4'h8, 4'h0, 4'hF, 4'hF, 64'h1234, 64'h409, 1'b1);
  endtask

  task automatic testShortForms();  // R2 R3 R5
    apply(64'h500, seq(80'h61_13_ff_ff_ff_ff_ff_ff_ff_ff), 1'b0);
    expectAll("R2", 4'h6, 4'h1, 4'h1, 4'h3, 64'h0, 64'h502, 1'b1);
    apply(64'h600, seq(80'h90_ff_ff_ff_ff_ff_ff_ff_ff_ff), 1'b0);
    expectAll("R3", 4'h9, 4'h0, 4'hF, 4'hF, 64'h0, 64'h601, 1'b1);
  endtask

  task automatic testIllegal();  // R6 R7
    apply(64'h700, seq(80'hc0_12_00_00_00_00_00_00_00_00), 1'b0);
    expectAll("R6", 4'hC, 4'h0, 4'hF, 4'hF, 64'h0, 64'h701, 1'b0);
    apply(64'h0, seq(80'h64_12_00_00_00_00_00_00_00_00), 1'b0);
    chk("R7", "alu fun4 valid", 64'(instrValid), 64'd0);
    apply(64'h0, seq(80'h27_12_00_00_00_00_00_00_00_00), 1'b0);
    chk("R7", "move fun7 valid", 64'(instrValid), 64'd0);
    apply(64'h0, seq(80'h26_12_00_00_00_00_00_00_00_00), 1'b0);
    chk("R7", "move fun6 valid", 64'(instrValid), 64'd1);
    apply(64'h0, seq(80'h11_00_00_00_00_00_00_00_00_00), 1'b0);
    chk("R7", "nop fun1 valid", 64'(instrValid), 64'd0);
  endtask

  task automatic testFault();  // R8
    apply(64'h800, seq(80'h61_13_ff_ff_ff_ff_ff_ff_ff_ff), 1'b1);
    expectAll("R8", 4'h1, 4'h0, 4'hF, 4'hF, 64'h0, 64'h801, 1'b1);
    apply(64'h900, seq(80'hf7_00_00_00_00_00_00_00_00_00), 1'b1);
    expectAll("R8", 4'h1, 4'h0, 4'hF, 4'hF, 64'h0, 64'h901, 1'b1);
  endtask

  task automatic testWrap();  // R5
    apply(64'hFFFF_FFFF_FFFF_FFF8, seq(80'h50_21_00_00_00_00_00_00_00_00), 1'b0);
    chk("R5", "wrap nextPc", nextPc, 64'h2);
  endtask

  task automatic testSweep();  // R1 R5 R6 R7 across all opcode bytes
    for (int b = 0; b < 256; b++) begin
      logic [3:0] c, f;
      logic regs, cst, ok;
      c = 4'(b >> 4); f = 4'(b);
      regs = (c == 4'h2 || c == 4'h3 || c == 4'h4 || c == 4'h5 || c == 4'h6 || c == 4'hA || c == 4'hB);
      cst  = (c == 4'h3 || c == 4'h4 || c == 4'h5 || c == 4'h7 || c == 4'h8);
      if (c > 4'hB) ok = 1'b0;
      else if (c == 4'h6) ok = (f <= 4'd3);
      else if (c == 4'h2 || c == 4'h7) ok = (f <= 4'd6);
      else ok = (f == 4'd0);
      apply(64'h1000, {72'h5a5a5a5a5a5a5a5a5a, 8'(b)}, 1'b0);
      chk("R1", "sweep code/fun", 64'({instrCode, instrFun}), 64'(b));
      chk("R7", "sweep valid", 64'(instrValid), 64'(ok));
      chk("R5", "sweep length", nextPc - 64'h1000, 64'(1 + int'(regs) + 8 * int'(cst)));
    end
  endtask

  initial begin
    pc = '0; fetchWindow = '0; imemError = 1'b0;
    repeat (2) @(posedge clk);
    testIdle();
    testExample();
    testImmMove();
    testJumpCall();
    testShortForms();
    testIllegal();
    testFault();
    testWrap();
    testSweep();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule